// File: doc/BRIEF.md
# Memory Access Handshake Controller

This block sits on the processor side of the path to main memory and carries out one read or one write at a time. The requester presents an address, a direction bit and, for a write, the data word. The controller loads the address into its memory address register and the write data into its memory data register. One cycle later it raises the read or the write strobe toward memory. It then waits for the memory to signal that the access has completed. On a read, the returned word is captured into the data register and offered to the requester together with a one-cycle completion pulse.

The controller supports two kinds of memory. With `USE_ACK` set, the memory drives a completion acknowledge. The controller stalls on it, and a timeout counter abandons the access with an error pulse if the acknowledge never comes. With `USE_ACK` cleared, there is no acknowledge. The controller instead holds the strobe for a fixed number of cycles and then completes. A busy output stays high for the whole of an access, and requests are taken only while the controller is idle.

Top module: `mem_xfer_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `busy`, `done`, `err`, `mem_rd` and `mem_wr` are all 0.
- R2: A request is accepted when `req_valid` is 1 and the controller is idle. In the next cycle `busy` is 1, `mem_addr` carries the request address and neither strobe is high. One cycle later `mem_rd` (when `req_write`=0) or `mem_wr` (when `req_write`=1) rises. The two strobes are never high together.
- R3: In acknowledge mode the strobe stays high until `mem_ack` is sampled at 1 on a rising edge, and it is low from the following cycle on.
- R4: While `mem_wr` is high, `mem_wdata` equals the write data of the accepted request. On a read, `rdata` equals the `mem_rdata` value sampled on the edge that completes the access, and it is valid in the cycle where `done` is 1.
- R5: In fixed-delay mode (`USE_ACK`=0) the strobe is high for exactly `FIXED_WAIT` cycles, whatever `mem_ack` does, and the access then completes with `done`.
- R6: `done` is a single-cycle pulse with `busy` high. `busy` stays high from the cycle after acceptance until the controller returns to idle.
- R7: A request raised while `busy` is 1 is not accepted. Changing the request inputs after acceptance does not alter the ongoing access, and no further access follows.
- R8: In acknowledge mode, after completion the controller keeps `busy` at 1 until `mem_ack` has been sampled at 0. `busy` falls one cycle after `mem_ack` is first seen low.
- R9: In acknowledge mode, if `mem_ack` stays 0 for `TIMEOUT` strobe cycles, the strobe drops, `err` pulses for one cycle with `busy` at 0, and `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until `busy` rises |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rdata | output | DATA_W | Read data, valid with `done` |
| mem_addr | output | ADDR_W | Address register toward memory |
| mem_wdata | output | DATA_W | Data register toward memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Data returned by memory |
| mem_ack | input | 1 | Completion acknowledge from memory |

## Verification
The bench builds two instances. The first uses `ADDR_W`=12, `DATA_W`=8, acknowledge mode and `TIMEOUT`=8. With that short timeout, an acknowledge that never arrives expires quickly. It also lets the bench vary acknowledge latency and the time the acknowledge is held, so strobe length and release timing can be checked. The second uses fixed-delay mode with `FIXED_WAIT`=3 and a toggling `mem_ack`. This shows that the count alone sets the strobe length in that mode.

// File: rtl/mxc_pkg.sv
package mxc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } mxc_state_e;

endpackage

// File: rtl/mxc_wait_cnt.sv
module mxc_wait_cnt #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mxc_regs.sv
module mxc_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic              dir_wr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mar    <= '0;
      mdr    <= '0;
      dir_wr <= 1'b0;
    end else if (load) begin
      mar    <= req_addr;
      mdr    <= req_wdata;
      dir_wr <= req_write;
    end else if (capture) begin
      mdr <= mem_rdata;
    end
  end

endmodule

// File: rtl/mxc_seq.sv
module mxc_seq
  import mxc_pkg::*;
#(
  parameter bit USE_ACK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       dir_wr,
  input  logic       mem_ack,
  input  logic       expired,
  output mxc_state_e state,
  output logic       load,
  output logic       capture,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       mem_rd,
  output logic       mem_wr
);

  logic complete;
  logic abort;

  generate
    if (USE_ACK) begin : g_ack
      assign complete = mem_ack;
      assign abort    = expired && !mem_ack;
    end else begin : g_fixed
      assign complete = expired;
      assign abort    = 1'b0;
    end
  endgenerate

  assign load    = (state == ST_IDLE) && req_valid;
  assign capture = (state == ST_WAIT) && complete && !dir_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state <= ST_ISSUE;
            busy  <= 1'b1;
          end
        end
        ST_ISSUE: begin
          state  <= ST_WAIT;
          mem_rd <= !dir_wr;
          mem_wr <= dir_wr;
        end
        ST_WAIT: begin
          if (complete) begin
            state  <= ST_DONE;
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
            done   <= 1'b1;
          end else if (abort) begin
            state  <= ST_IDLE;
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
            busy   <= 1'b0;
            err    <= 1'b1;
          end
        end
        ST_DONE: begin
          if (!USE_ACK || !mem_ack) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mem_xfer_ctrl.sv
module mem_xfer_ctrl
  import mxc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter bit USE_ACK    = 1'b1,
  parameter int FIXED_WAIT = 4,
  parameter int TIMEOUT    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int LIMIT = USE_ACK ? TIMEOUT : FIXED_WAIT;

  mxc_state_e        state;
  logic              load;
  logic              capture;
  logic              dir_wr;
  logic              expired;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;

  mxc_seq #(
    .USE_ACK (USE_ACK)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .dir_wr    (dir_wr),
    .mem_ack   (mem_ack),
    .expired   (expired),
    .state     (state),
    .load      (load),
    .capture   (capture),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  mxc_wait_cnt #(
    .LIMIT (LIMIT)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_WAIT),
    .expired (expired)
  );

  mxc_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_rdata (mem_rdata),
    .mar       (mar),
    .mdr       (mdr),
    .dir_wr    (dir_wr)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign rdata     = mdr;

endmodule

// File: rtl/mxc_chk.sv
module mxc_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter bit USE_ACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r2_addr_settled: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd || mem_wr) |-> $stable(mem_addr));

  a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (USE_ACK && (mem_rd || mem_wr) && mem_ack) |=> !(mem_rd || mem_wr));

  a_r4_wdata_steady: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> $stable(mem_wdata));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mem_wr));

  a_r8_ack_released: assert property (@(posedge clk) disable iff (rst)
    (USE_ACK && $fell(busy) && !err) |-> !$past(mem_ack));

  a_r9_err_alone: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done));

  a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

endmodule

bind mem_xfer_ctrl mxc_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .USE_ACK (USE_ACK)
) u_mxc_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_mem_xfer_ctrl.sv
`timescale 1ns/1ps
module test_mem_xfer_ctrl;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int TMO = 8;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // acknowledge-mode instance
  logic          rv = 1'b0, rw = 1'b0;
  logic [AW-1:0] ra = '0;
  logic [DW-1:0] rwd = '0;
  logic          busy, done, err, mrd, mwr;
  logic [DW-1:0] rdat, mwd, mrdat;
  logic [AW-1:0] maddr;
  logic          mack;

  mem_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .USE_ACK(1'b1),
                  .FIXED_WAIT(FW), .TIMEOUT(TMO)) i_mem_xfer_ctrl (
    .clk(clk), .rst(rst), .req_valid(rv), .req_write(rw), .req_addr(ra),
    .req_wdata(rwd), .busy(busy), .done(done), .err(err), .rdata(rdat),
    .mem_addr(maddr), .mem_wdata(mwd), .mem_rd(mrd), .mem_wr(mwr),
    .mem_rdata(mrdat), .mem_ack(mack));

  // fixed-delay instance
  logic          frv = 1'b0, frw = 1'b0, fack = 1'b0;
  logic [AW-1:0] fra = '0;
  logic [DW-1:0] frwd = '0;
  logic          fbusy, fdone, ferr, fmrd, fmwr;
  logic [DW-1:0] frdat, fmwd, fmrdat;
  logic [AW-1:0] fmaddr;

  mem_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .USE_ACK(1'b0),
                  .FIXED_WAIT(FW), .TIMEOUT(TMO)) i_mem_xfer_ctrl_fixed (
    .clk(clk), .rst(rst), .req_valid(frv), .req_write(frw), .req_addr(fra),
    .req_wdata(frwd), .busy(fbusy), .done(fdone), .err(ferr), .rdata(frdat),
    .mem_addr(fmaddr), .mem_wdata(fmwd), .mem_rd(fmrd), .mem_wr(fmwr),
    .mem_rdata(fmrdat), .mem_ack(fack));

  // memory model with acknowledge
  logic [DW-1:0] bmem [16];
  int ack_dly = 0, hold_extra = 0, rcnt = 0, hcnt = 0;
  bit no_ack = 1'b0;

  assign mrdat = bmem[maddr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      mack <= 1'b0;
      rcnt <= 0;
      hcnt <= 0;
      for (int i = 0; i < 16; i++) bmem[i] <= 8'h90 + 8'(i);
    end else if ((mrd || mwr) && !mack) begin
      if (!no_ack) begin
        if (rcnt == ack_dly) begin
          mack <= 1'b1;
          rcnt <= 0;
          if (mwr) bmem[maddr[3:0]] <= mwd;
        end else begin
          rcnt <= rcnt + 1;
        end
      end
    end else if (mack && !(mrd || mwr)) begin
      if (hcnt == hold_extra) begin
        mack <= 1'b0;
        hcnt <= 0;
      end else begin
        hcnt <= hcnt + 1;
      end
    end
  end

  // memory model without acknowledge
  logic [DW-1:0] fmem [16];
  assign fmrdat = fmem[fmaddr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) fmem[i] <= 8'h40 + 8'(i);
    end else if (fmwr) begin
      fmem[fmaddr[3:0]] <= fmwd;
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog: actual=%0d expected<50000", cyc);
      summary();
      $finish;
    end
  end

  // one access on the acknowledge-mode instance
  task automatic xfer(input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int dly, input int hold,
                      input bit poke, output logic [DW-1:0] got);
    int stb = 0;
    bit fin = 0;
    got = '0;
    ack_dly = dly;
    hold_extra = hold;
    rv = 1'b1; rw = w; ra = a; rwd = d;
    @(negedge clk);
    chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
    chk(maddr == a && !mrd && !mwr, "R2", "address before strobe", maddr, a);
    rv = 1'b0; ra = ~a; rwd = ~d; rw = ~w;   // R7: late changes are ignored
    for (int k = 0; k < 64 && !fin; k++) begin
      @(negedge clk);
      if (mrd || mwr) begin
        stb++;
        chk(mrd == !w && mwr == w, "R2", "strobe direction", {mrd, mwr}, {!w, w});
        chk(maddr == a, "R7", "address held", maddr, a);
        if (w) chk(mwd == d, "R4", "write data", mwd, d);
        if (poke && stb == 1) begin
          rv = 1'b1; ra = 12'h0EE;
        end else begin
          rv = 1'b0;
        end
      end
      if (done) begin
        fin = 1;
        got = rdat;
      end
    end
    rv = 1'b0;
    chk(fin, "R3", "completion seen", fin, 1);
    chk(stb == dly + 2, "R3", "strobe length", stb, dly + 2);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done one cycle", done, 0);
    for (int k = 0; k < 32 && mack; k++) begin
      chk(busy == 1'b1, "R8", "busy while ack high", busy, 1);
      @(negedge clk);
    end
    chk(busy == 1'b1, "R8", "busy when ack first low", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "release after ack low", busy, 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!busy && !mrd && !mwr, "R7", "no access from busy-time request",
            {busy, mrd, mwr}, 0);
      end
    end
  endtask

  // one access on the fixed-delay instance
  task automatic fxfer(input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] got);
    int stb = 0;
    bit fin = 0;
    got = '0;
    frv = 1'b1; frw = w; fra = a; frwd = d;
    @(negedge clk);
    frv = 1'b0;
    for (int k = 0; k < 32 && !fin; k++) begin
      @(negedge clk);
      fack = ~fack;
      if (fmrd || fmwr) stb++;
      if (fdone) begin
        fin = 1;
        got = frdat;
      end
    end
    chk(fin && stb == FW, "R5", "fixed strobe length", stb, FW);
    @(negedge clk);
    chk(!fbusy && !fdone, "R6", "fixed release", {fbusy, fdone}, 0);
  endtask

  typedef struct packed {
    logic          w;
    logic [AW-1:0] a;
    logic [DW-1:0] d;    // write data, or expected read data
    logic [3:0]    dly;
    logic [3:0]    hold;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 12'h005, 8'h3C, 4'd0, 4'd0},
    '{1'b1, 12'h00A, 8'hC5, 4'd2, 4'd1},
    '{1'b0, 12'h005, 8'h3C, 4'd1, 4'd0},
    '{1'b0, 12'h00A, 8'hC5, 4'd0, 4'd3},
    '{1'b1, 12'h105, 8'h7E, 4'd3, 4'd0},
    '{1'b0, 12'h005, 8'h7E, 4'd4, 4'd2},
    '{1'b0, 12'h00F, 8'h9F, 4'd0, 4'd0},
    '{1'b1, 12'hFFF, 8'h00, 4'd1, 4'd0},
    '{1'b0, 12'h00F, 8'h00, 4'd5, 4'd1}
  };

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mrd && !mwr, "R1", "in reset",
        {busy, done, err, mrd, mwr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !mrd && !mwr && !fbusy, "R1", "after reset",
        {busy, done, err, mrd, mwr}, 0);

    for (int i = 0; i < 9; i++) begin
      xfer(VEC[i].w, VEC[i].a, VEC[i].d, int'(VEC[i].dly), int'(VEC[i].hold),
           1'b0, got);
      if (!VEC[i].w) chk(got == VEC[i].d, "R4", "read data", got, VEC[i].d);
    end

    // R7: request raised mid-access
    xfer(1'b0, 12'h00A, 8'h00, 3, 0, 1'b1, got);
    chk(got == 8'hC5, "R4", "read data after poke", got, 8'hC5);

    // R9: memory never acknowledges
    begin
      int stb = 0;
      bit e = 0;
      no_ack = 1'b1;
      rv = 1'b1; rw = 1'b0; ra = 12'h003;
      @(negedge clk);
      rv = 1'b0;
      for (int k = 0; k < 40 && !e; k++) begin
        @(negedge clk);
        if (mrd) stb++;
        chk(!done, "R9", "no done on timeout", done, 0);
        if (err) begin
          e = 1;
          chk(!busy && !mrd, "R9", "idle with error", {busy, mrd}, 0);
        end
      end
      chk(e && stb == TMO, "R9", "timeout strobe length", stb, TMO);
      @(negedge clk);
      chk(!err, "R9", "error one cycle", err, 0);
      no_ack = 1'b0;
    end
    xfer(1'b0, 12'h005, 8'h7E, 0, 0, 1'b0, got);
    chk(got == 8'h7E, "R9", "access works after timeout", got, 8'h7E);

    // R5: fixed-delay mode
    fxfer(1'b1, 12'h003, 8'h81, got);
    fxfer(1'b0, 12'h003, 8'h00, got);
    chk(got == 8'h81, "R5", "fixed read back", got, 8'h81);
    fxfer(1'b0, 12'h009, 8'h00, got);
    chk(got == 8'h49, "R5", "fixed read initial", got, 8'h49);

    summary();
    $finish;
  end

endmodule